// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from the moment supply and clock are good to the point where normal traffic may begin. It drives the chip-select, row-strobe, column-strobe and write-enable lines, the address bus and the bank select. It then raises a completion flag that stays high. Every wait is a cycle count set by a parameter, and the mode word is built from parameters. Nothing is programmable at run time.

The sequence is fixed:
- a NOP-only hold of `PWRUP_CYC` cycles once `pwr_ok` is seen high;
- one precharge covering all banks;
- exactly two auto-refresh commands;
- a mode-register load;
- a final settling wait, after which `init_done` rises.

A NOP is driven in every cycle that carries no command. The command pins are registered, so each pin value lags the state that chose it by one cycle.

The state machine has these states:
- `ST_IDLE`: waiting for `pwr_ok`.
- `ST_PWRUP`: the power-up hold.
- `ST_PRE` → `ST_PRE_WAIT`.
- `ST_REF1` → `ST_REF1_WAIT`.
- `ST_REF2` → `ST_REF2_WAIT`.
- `ST_LMR` → `ST_LMR_WAIT`.
- `ST_DONE`, which has no exit.

Its transitions are:
- `ST_IDLE`→`ST_PWRUP` when `pwr_ok` is high.
- `ST_PWRUP`→`ST_IDLE` when `pwr_ok` drops.
- `ST_PWRUP`→`ST_PRE` when the timer expires.
- Each command state moves to its wait state after one cycle and loads the timer.
- Each wait state moves to the next command state when the timer expires.
- `ST_LMR_WAIT`→`ST_DONE` when the timer expires.
- Reset from any state goes to `ST_IDLE`.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the pins drive NOP ({cs_n,ras_n,cas_n,we_n} = 0111), with `addr` = 0, `ba` = 0 and `init_done` = 0.
- R2: After reset, while `pwr_ok` stays low, only NOP appears and `init_done` stays 0.
- R3: Precharge-all (0010, `addr` bit 10 = 1, other address bits 0, `ba` = 0) appears on the pins exactly `PWRUP_CYC`+1 cycles after the first clock edge that samples `pwr_ok` high. Only NOP is driven before it.
- R4: If `pwr_ok` falls during the power-up hold, no command is issued. The hold restarts in full at the next rise.
- R5: The first auto-refresh (0001, `addr` = 0) appears exactly `PRE_GAP` cycles after the precharge.
- R6: The second auto-refresh appears exactly `REF_GAP` cycles after the first. No more than two refreshes are issued.
- R7: The mode load (0000, `ba` = 0) appears exactly `REF_LMR_GAP` cycles after the second refresh. Its address carries the mode word:
  - burst length code in bits 2:0;
  - interleaved burst type in bit 3;
  - CAS latency in bits 6:4 (2 → 010, 3 → 011);
  - 00 in bits 8:7;
  - single-location write in bit 9;
  - 00 in bits 11:10.
- R8: Every cycle between commands carries NOP. Exactly four commands are issued per sequence, and the wait timer counts down by one per cycle without wrapping.
- R9: `init_done` rises exactly `LMR_GAP` cycles after the mode load. It then stays high with only NOP on the pins.
- R10: A reset part way through the sequence drops `init_done` and the pins to the R1 state. After release, the whole sequence runs again from the power-up hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply and clock stable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (A10 = all-banks flag, mode word on load) |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | Sequence complete, held high |

## Verification
The bench measures the exact cycle of every command relative to the previous one. An off-by-one in any wait, or one caused by the output register, shows up as a wrong gap rather than passing silently.

It interrupts the power-up hold by dropping `pwr_ok`. A design that kept counting would precharge early, and one that ignored the drop would issue commands during the interrupted window.

It applies reset after the precharge has gone out. A design that kept its refresh count or its done flag would skip or duplicate commands on the rerun.

The mode word uses a non-zero value in every field, so a swapped or shifted field changes the observed address.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_PRE,
        ST_PRE_WAIT,
        ST_REF1,
        ST_REF1_WAIT,
        ST_REF2,
        ST_REF2_WAIT,
        ST_LMR,
        ST_LMR_WAIT,
        ST_DONE
    } init_state_e;

    // Address bit that selects all banks on a precharge
    localparam int ALL_BANK_BIT = 10;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Timer load for a command-to-command spacing of g cycles:
    // one cycle in the command state plus g-1 in the wait state.
    function automatic int gap_load(input int g);
        return (g < 2) ? 0 : g - 2;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: the timer stops at zero instead of wrapping
    a_r8_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

    // R8: one step per cycle while running
    a_r8_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int          ADDR_W       = 12,
    parameter logic [2:0]  BURST_CODE   = 3'b011,
    parameter bit          INTERLEAVE   = 1'b0,
    parameter int          CAS_LAT      = 3,
    parameter bit          WRITE_SINGLE = 1'b0
) (
    output logic [ADDR_W-1:0] word
);

    localparam logic [2:0]  CL_CODE = 3'(CAS_LAT);
    localparam logic [11:0] WORD12  = {2'b00, WRITE_SINGLE, 2'b00, CL_CODE,
                                       INTERLEAVE, BURST_CODE};

    always_comb begin
        word        = '0;
        word[11:0]  = WORD12;
    end

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdram_cmd_e        cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BA_W-1:0]   ba_in,
    input  logic              done_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            addr                       <= '0;
            ba                         <= '0;
            done                       <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_in;
            addr                       <= addr_in;
            ba                         <= ba_in;
            done                       <= done_in;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int         ADDR_W           = 12,
    parameter int         BA_W             = 2,
    parameter int         PWRUP_CYC        = 25000,
    parameter int         PRE_GAP          = 3,
    parameter int         REF_GAP          = 10,
    parameter int         REF_LMR_GAP      = 10,
    parameter int         LMR_GAP          = 2,
    parameter logic [2:0] BURST_CODE       = 3'b011,
    parameter bit         BURST_INTERLEAVE = 1'b0,
    parameter int         CAS_LAT          = 3,
    parameter bit         WRITE_SINGLE     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int MAX_WAIT = max_int(PWRUP_CYC,
                              max_int(PRE_GAP,
                              max_int(REF_GAP,
                              max_int(REF_LMR_GAP, LMR_GAP))));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'((PWRUP_CYC < 1) ? 0 : PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(gap_load(PRE_GAP));
    localparam logic [CNT_W-1:0] LD_REF   = CNT_W'(gap_load(REF_GAP));
    localparam logic [CNT_W-1:0] LD_RLMR  = CNT_W'(gap_load(REF_LMR_GAP));
    localparam logic [CNT_W-1:0] LD_LMR   = CNT_W'(gap_load(LMR_GAP));

    init_state_e       state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;

    sdram_cmd_e        cmd_d;
    logic [ADDR_W-1:0] addr_d;
    logic [BA_W-1:0]   ba_d;
    logic              done_d;
    logic [ADDR_W-1:0] mode_word;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_ok) begin
                    state_d  = ST_PWRUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PWRUP;
                end
            end
            ST_PWRUP: begin
                if (!pwr_ok) begin
                    state_d = ST_IDLE;
                end else if (tmr_expired) begin
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                state_d  = ST_PRE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_PRE;
            end
            ST_PRE_WAIT: begin
                if (tmr_expired) state_d = ST_REF1;
            end
            ST_REF1: begin
                state_d  = ST_REF1_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_REF;
            end
            ST_REF1_WAIT: begin
                if (tmr_expired) state_d = ST_REF2;
            end
            ST_REF2: begin
                state_d  = ST_REF2_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_RLMR;
            end
            ST_REF2_WAIT: begin
                if (tmr_expired) state_d = ST_LMR;
            end
            ST_LMR: begin
                state_d  = ST_LMR_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_LMR;
            end
            ST_LMR_WAIT: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Command selection per state
    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        ba_d   = '0;
        unique case (state_q)
            ST_PRE: begin
                cmd_d                = CMD_PRE;
                addr_d[ALL_BANK_BIT] = 1'b1;
            end
            ST_REF1, ST_REF2: begin
                cmd_d = CMD_REF;
            end
            ST_LMR: begin
                cmd_d  = CMD_LMR;
                addr_d = mode_word;
            end
            default: begin
                cmd_d = CMD_NOP;
            end
        endcase
    end

    assign done_d = (state_q == ST_DONE);

    sdram_init_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_word #(
        .ADDR_W       (ADDR_W),
        .BURST_CODE   (BURST_CODE),
        .INTERLEAVE   (BURST_INTERLEAVE),
        .CAS_LAT      (CAS_LAT),
        .WRITE_SINGLE (WRITE_SINGLE)
    ) mode_i (
        .word (mode_word)
    );

    sdram_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) drive_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_in  (cmd_d),
        .addr_in (addr_d),
        .ba_in   (ba_d),
        .done_in (done_d),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .ba      (ba),
        .done    (init_done)
    );

    // Pin-side observation for the assertions below
    logic [3:0] pin_cmd;
    logic [1:0] refs_seen_q;

    assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refs_seen_q <= '0;
        end else if (pin_cmd == CMD_REF && refs_seen_q != 2'd3) begin
            refs_seen_q <= refs_seen_q + 1'b1;
        end
    end

    // R2, R3: nothing but NOP leaves the block before or during the hold
    a_r2_hold_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_PWRUP) |=> (pin_cmd == CMD_NOP));

    // R3: the precharge covers all banks
    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRE) |-> (addr[ALL_BANK_BIT] && ba == '0));

    // R6: never a third refresh
    a_r6_two_refreshes: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_REF) |-> (refs_seen_q < 2'd2));

    // R7: mode load only after both refreshes, reserved fields clear
    a_r7_load_after_refs: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LMR) |-> (refs_seen_q == 2'd2 && addr[11:10] == 2'b00
                                  && addr[8:7] == 2'b00));

    // R9: completion is held
    a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9: quiet bus once complete
    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pin_cmd == CMD_NOP));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

    localparam int PWR   = 20;
    localparam int PREG  = 3;
    localparam int REFG  = 7;
    localparam int RLMRG = 5;
    localparam int LMRG  = 2;
    localparam logic [3:0] NOP = 4'b0111;

    // Row: {expected command (F = done flag), gap from previous event, address}
    localparam logic [31:0] EXP_TBL [5] = '{
        {4'h2, 12'(PWR + 1), 16'h0400},
        {4'h1, 12'(PREG),    16'h0000},
        {4'h1, 12'(REFG),    16'h0000},
        {4'h0, 12'(RLMRG),   16'h023A},
        {4'hF, 12'(LMRG),    16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pwr_ok;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic        init_done;
    logic [3:0]  pin_cmd;

    assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

    always #2 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W           (12),
        .BA_W             (2),
        .PWRUP_CYC        (PWR),
        .PRE_GAP          (PREG),
        .REF_GAP          (REFG),
        .REF_LMR_GAP      (RLMRG),
        .LMR_GAP          (LMRG),
        .BURST_CODE       (3'b010),
        .BURST_INTERLEAVE (1'b1),
        .CAS_LAT          (3),
        .WRITE_SINGLE     (1'b1)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) cyc = cyc + 1;

    // Event log, sampled at the falling edge
    int         ev_cyc  [8];
    logic [3:0] ev_code [8];
    logic [11:0] ev_addr [8];
    logic [1:0] ev_ba   [8];
    int         n_ev     = 0;
    int         done_cyc = -1;
    bit         log_en   = 1'b0;

    always @(negedge clk) begin
        if (log_en) begin
            if (pin_cmd != NOP) begin
                if (n_ev < 8) begin
                    ev_cyc[n_ev]  = cyc;
                    ev_code[n_ev] = pin_cmd;
                    ev_addr[n_ev] = addr;
                    ev_ba[n_ev]   = ba;
                end
                n_ev = n_ev + 1;
            end
            if (init_done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        n_ev     = 0;
        done_cyc = -1;
        log_en   = 1'b1;
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check_run(input int start_cyc, input string ctx);
        int prev = start_cyc;
        for (int i = 0; i < 5; i++) begin
            logic [3:0] code = EXP_TBL[i][31:28];
            int         gap  = int'(EXP_TBL[i][27:16]);
            int         xadr = int'(EXP_TBL[i][15:0]);
            string      tg   = $sformatf("%s %s row%0d", row_tag(i), ctx, i);
            if (code == 4'hF) begin
                chk({tg, " done gap"}, done_cyc - prev, gap);
            end else if (i < n_ev) begin
                chk({tg, " cmd"},  int'(ev_code[i]), int'(code));
                chk({tg, " gap"},  ev_cyc[i] - prev, gap);
                chk({tg, " addr"}, int'(ev_addr[i]), xadr);
                chk({tg, " ba"},   int'(ev_ba[i]), 0);
                prev = ev_cyc[i];
            end else begin
                chk({tg, " missing event"}, n_ev, i + 1);
            end
        end
        chk({"R8 ", ctx, " command count"}, n_ev, 4);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk  = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int pwr_cyc;
        rst_n  = 1'b0;
        pwr_ok = 1'b0;
        tick(3);

        // R1: reset state
        @(negedge clk);
        chk("R1 reset cmd",  int'(pin_cmd), int'(NOP));
        chk("R1 reset addr", int'(addr), 0);
        chk("R1 reset ba",   int'(ba), 0);
        chk("R1 reset done", int'(init_done), 0);
        tick(1);
        rst_n = 1'b1;

        // R2: no power-good, nothing happens
        clear_log();
        tick(15);
        chk("R2 commands without pwr_ok", n_ev, 0);
        chk("R2 done without pwr_ok", int'(done_cyc >= 0), 0);

        // R4: interrupted hold issues nothing, then restarts in full
        pwr_ok = 1'b1;
        tick(PWR - 4);
        pwr_ok = 1'b0;
        tick(3);
        chk("R4 commands in interrupted hold", n_ev, 0);

        clear_log();
        pwr_ok  = 1'b1;
        pwr_cyc = cyc + 1;
        tick(70);
        check_run(pwr_cyc, "main");

        // R9: done held, bus quiet
        chk("R9 done high", int'(init_done), 1);
        tick(25);
        chk("R9 done still high", int'(init_done), 1);
        chk("R9 no later commands", n_ev, 4);

        // R10: reset mid-sequence
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        clear_log();
        pwr_cyc = cyc + 1;
        tick(PWR + 1 + PREG + 2);
        chk("R10 started before reset", int'(n_ev >= 1), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset cmd",  int'(pin_cmd), int'(NOP));
        chk("R10 reset done", int'(init_done), 0);
        tick(2);
        rst_n = 1'b1;
        clear_log();
        pwr_cyc = cyc + 1;
        tick(70);
        check_run(pwr_cyc, "rerun");
        chk("R10 done after rerun", int'(init_done), 1);

        finish_up();
    end

endmodule